// File: doc/BRIEF.md
# Pixel Write-Function Compositing Unit

This unit sits between a 32-bit write bus and a single-port synchronous pixel memory. It looks at the upper address bits of each bus request to find the window the request falls in. A write to the plain window stores the bus data directly. A write to one of four function windows becomes a read-modify-write. The unit reads the stored word (B), combines it pixel by pixel with the bus word (A) using the arithmetic function that window selects, and writes the result back to the same word.

Each 32-bit word holds sixteen 2-bit pixels. Codes 0 to 3 stand for intensities 0 to 1, and all sixteen lanes are combined in parallel. Reads are served only through the plain window.

The window size and the window indices are parameters, so the same unit serves a large main memory with 64 MiB windows or a smaller video memory with 16 MiB windows. The bus holds its request stable until ready is seen high. The transfer completes at the clock edge where req and ready are both high.

Top module: `wf_composite_unit`

## Requirements
- R1: A write whose window index `addr[31:WIN_SHIFT]` equals PLAIN_IDX (default 1, base 0x04000000) stores `wdata` at word `addr[MEM_AW+1:2]`. It raises ready in the same cycle it is presented.
- R2: A read in the plain window issues one memory read. Ready and `rdata` follow one cycle later. `rdata` is 0 in every cycle that does not complete a plain read.
- R3: Window index FUNC_IDX+3 (default base 0x1C000000) writes floor(a*b/3) per pixel, where a is the bus pixel and b is the stored pixel.
- R4: Window index FUNC_IDX+2 (default base 0x18000000) writes 3 when a+b is non-zero and 0 otherwise.
- R5: Window index FUNC_IDX+1 (default base 0x14000000) writes floor((3-a)*b/3) per pixel.
- R6: Window index FUNC_IDX (default base 0x10000000) writes min(3, a+b-floor(a*b/3)) per pixel.
- R7: Pixel i occupies bits [2i+1:2i] of the word, and every lane is combined independently of the other fifteen.
- R8: A function-window write reads memory in its first cycle with ready low. It writes the combined word back in its second cycle with ready high, to the same word address `addr[MEM_AW+1:2]` that a plain access reaches.
- R9: A request outside every window, or a read of a function window, gets ready in its first cycle. It performs no memory access, returns `rdata` 0 and leaves memory unchanged.
- R10: After reset, and whenever req is low, ready and mem_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Bus request, held until ready |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Write data (A pixels) |
| ready | output | 1 | Transfer completes this cycle |
| rdata | output | 32 | Read data, valid with ready on a plain read |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 6 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the read |

## Verification
The bench builds a word whose sixteen lanes hold all sixteen (a,b) pairs and pushes it through every function. A swapped operand, a wrong rounding or a missing saturation therefore shows up in a specific lane.

Each transfer's latency is counted. A design that raised ready during the read phase would finish one cycle early and write stale data back.

Function writes to the last word, followed by a plain read, expose an alias that drops address bits. Out-of-window writes and function-window reads are followed by readback, which catches a decoder that lets them touch memory.

// File: rtl/wf_pkg.sv
package wf_pkg;

  typedef enum logic [1:0] {
    FN_SCREEN = 2'd0,
    FN_ERASE  = 2'd1,
    FN_CEIL   = 2'd2,
    FN_MUL    = 2'd3
  } wf_func_e;

  typedef enum logic [1:0] {
    WIN_NONE  = 2'd0,
    WIN_PLAIN = 2'd1,
    WIN_FUNC  = 2'd2
  } wf_win_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RDATA = 2'd1,
    ST_WBACK = 2'd2
  } wf_state_e;

  // combine one 2-bit pixel: a = incoming, b = stored
  function automatic logic [1:0] wf_combine(wf_func_e fn, logic [1:0] a, logic [1:0] b);
    logic [3:0] prod_q;
    logic [3:0] inv_q;
    logic [3:0] scr;
    logic [1:0] res;
    prod_q = ({2'b00, a} * {2'b00, b}) / 4'd3;
    inv_q  = ({2'b00, 2'd3 - a} * {2'b00, b}) / 4'd3;
    scr    = {2'b00, a} + {2'b00, b} - prod_q;
    case (fn)
      FN_MUL:   res = prod_q[1:0];
      FN_CEIL:  res = ((a | b) != 2'd0) ? 2'd3 : 2'd0;
      FN_ERASE: res = inv_q[1:0];
      default:  res = (scr > 4'd3) ? 2'd3 : scr[1:0];
    endcase
    return res;
  endfunction

endpackage

// File: rtl/wf_decode.sv
module wf_decode
  import wf_pkg::*;
#(
  parameter int BUS_AW    = 32,
  parameter int WIN_SHIFT = 26,
  parameter int PLAIN_IDX = 1,
  parameter int FUNC_IDX  = 4
) (
  input  logic [BUS_AW-1:0] addr,
  output wf_win_e           win,
  output wf_func_e          fn
);
  localparam int SEL_W = BUS_AW - WIN_SHIFT;

  logic [SEL_W-1:0] sel;
  logic [SEL_W-1:0] offs;

  assign sel  = addr[BUS_AW-1:WIN_SHIFT];
  assign offs = sel - SEL_W'(FUNC_IDX);

  always_comb begin
    win = WIN_NONE;
    fn  = wf_func_e'(offs[1:0]);
    if (sel == SEL_W'(PLAIN_IDX)) begin
      win = WIN_PLAIN;
    end else if ((sel >= SEL_W'(FUNC_IDX)) && (offs < SEL_W'(4))) begin
      win = WIN_FUNC;
    end
  end
endmodule

// File: rtl/wf_pixel_alu.sv
module wf_pixel_alu
  import wf_pkg::*;
#(
  parameter int DW = 32
) (
  input  wf_func_e        fn,
  input  logic [DW-1:0]   a_word,
  input  logic [DW-1:0]   b_word,
  output logic [DW-1:0]   y_word
);
  localparam int NPIX = DW / 2;

  for (genvar i = 0; i < NPIX; i++) begin : g_lane
    assign y_word[2*i +: 2] = wf_combine(fn, a_word[2*i +: 2], b_word[2*i +: 2]);
  end
endmodule

// File: rtl/wf_ctrl.sv
module wf_ctrl
  import wf_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req,
  input  logic    we,
  input  wf_win_e win,
  output logic    mem_en,
  output logic    mem_we,
  output logic    ready,
  output logic    rd_phase,
  output logic    wb_phase
);
  wf_state_e state_q, state_d;
  logic      state_en;

  always_comb begin
    state_d  = state_q;
    mem_en   = 1'b0;
    mem_we   = 1'b0;
    ready    = 1'b0;
    rd_phase = 1'b0;
    wb_phase = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req) begin
          case (win)
            WIN_PLAIN: begin
              mem_en = 1'b1;
              if (we) begin
                mem_we = 1'b1;
                ready  = 1'b1;
              end else begin
                state_d = ST_RDATA;
              end
            end
            WIN_FUNC: begin
              if (we) begin
                mem_en  = 1'b1;
                state_d = ST_WBACK;
              end else begin
                ready = 1'b1;
              end
            end
            default: ready = 1'b1;
          endcase
        end
      end
      ST_RDATA: begin
        ready    = 1'b1;
        rd_phase = 1'b1;
        state_d  = ST_IDLE;
      end
      ST_WBACK: begin
        mem_en   = 1'b1;
        mem_we   = 1'b1;
        ready    = 1'b1;
        wb_phase = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end
endmodule

// File: rtl/wf_composite_unit.sv
module wf_composite_unit
  import wf_pkg::*;
#(
  parameter int DW        = 32,
  parameter int BUS_AW    = 32,
  parameter int MEM_AW    = 6,
  parameter int WIN_SHIFT = 26,
  parameter int PLAIN_IDX = 1,
  parameter int FUNC_IDX  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [BUS_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic              ready,
  output logic [DW-1:0]     rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata
);
  localparam int WORD_LSB = $clog2(DW / 8);

  logic     rst_meta_q, rst_sync_n;
  wf_win_e  win;
  wf_func_e fn;
  logic     rd_phase, wb_phase;
  logic [DW-1:0] combined;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  wf_decode #(
    .BUS_AW(BUS_AW), .WIN_SHIFT(WIN_SHIFT),
    .PLAIN_IDX(PLAIN_IDX), .FUNC_IDX(FUNC_IDX)
  ) u_decode (
    .addr(addr), .win(win), .fn(fn)
  );

  wf_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .req(req), .we(we), .win(win),
    .mem_en(mem_en), .mem_we(mem_we), .ready(ready),
    .rd_phase(rd_phase), .wb_phase(wb_phase)
  );

  wf_pixel_alu #(.DW(DW)) u_alu (
    .fn(fn), .a_word(wdata), .b_word(mem_rdata), .y_word(combined)
  );

  assign mem_addr  = addr[MEM_AW+WORD_LSB-1:WORD_LSB];
  assign mem_wdata = wb_phase ? combined : wdata;
  assign rdata     = rd_phase ? mem_rdata : '0;
endmodule

// File: rtl/wf_composite_chk.sv
module wf_composite_chk #(
  parameter int DW        = 32,
  parameter int BUS_AW    = 32,
  parameter int MEM_AW    = 6,
  parameter int WIN_SHIFT = 26,
  parameter int PLAIN_IDX = 1,
  parameter int FUNC_IDX  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              we,
  input logic [BUS_AW-1:0] addr,
  input logic              ready,
  input logic [DW-1:0]     rdata,
  input logic              mem_en,
  input logic              mem_we,
  input logic [MEM_AW-1:0] mem_addr
);
  localparam int SEL_W = BUS_AW - WIN_SHIFT;

  logic [SEL_W-1:0] idx;
  logic plain_hit, func_hit, start_ok, fresh_q;

  assign idx       = addr[BUS_AW-1:WIN_SHIFT];
  assign plain_hit = (int'(idx) == PLAIN_IDX);
  assign func_hit  = (int'(idx) >= FUNC_IDX) && (int'(idx) < FUNC_IDX + 4);
  assign start_ok  = fresh_q && req;

  // next cycle begins a new transfer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fresh_q <= 1'b1;
    else        fresh_q <= !req || ready;
  end

  p_plain_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok && we && plain_hit |-> mem_en && mem_we && ready);

  p_plain_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok && !we && plain_hit |=> ready && !mem_en);

  p_rmw_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok && we && func_hit |-> mem_en && !mem_we && !ready);

  p_rmw_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok && we && func_hit |=> mem_en && mem_we && ready && $stable(mem_addr));

  p_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok && !plain_hit && !(func_hit && we) |-> ready && !mem_en && (rdata == '0));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> !ready && !mem_en);
endmodule

bind wf_composite_unit wf_composite_chk #(
  .DW(DW), .BUS_AW(BUS_AW), .MEM_AW(MEM_AW), .WIN_SHIFT(WIN_SHIFT),
  .PLAIN_IDX(PLAIN_IDX), .FUNC_IDX(FUNC_IDX)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .req(req), .we(we), .addr(addr),
  .ready(ready), .rdata(rdata), .mem_en(mem_en), .mem_we(mem_we),
  .mem_addr(mem_addr)
);

// File: tb/tb_wf_composite_unit.sv
`timescale 1ns/1ps
module tb_wf_composite_unit;
  localparam logic [31:0] PLAIN = 32'h0400_0000;
  localparam logic [31:0] F1 = 32'h1C00_0000;
  localparam logic [31:0] F2 = 32'h1800_0000;
  localparam logic [31:0] F3 = 32'h1400_0000;
  localparam logic [31:0] F4 = 32'h1000_0000;

  logic clk, rst_n, req, we, ready, mem_en, mem_we;
  logic [31:0] addr, wdata, rdata, mem_wdata, mem_rdata;
  logic [5:0] mem_addr;
  logic [31:0] mem [64];
  int n_run, n_fail;
  bit finished;

  wf_composite_unit dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always_ff @(posedge clk) begin
    if (mem_en && mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_en && !mem_we) mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] ref_pix(input int f, input int a, input int b);
    int r;
    case (f)
      1: r = (a * b) / 3;
      2: r = (a + b != 0) ? 3 : 0;
      3: r = ((3 - a) * b) / 3;
      default: begin r = a + b - (a * b) / 3; if (r > 3) r = 3; end
    endcase
    return 2'(r);
  endfunction

  function automatic logic [31:0] ref_word(input int f, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] y;
    for (int i = 0; i < 16; i++) y[2*i +: 2] = ref_pix(f, int'(a[2*i +: 2]), int'(b[2*i +: 2]));
    return y;
  endfunction

  function automatic logic [31:0] fbase(input int f);
    case (f)
      1: return F1;
      2: return F2;
      3: return F3;
      default: return F4;
    endcase
  endfunction

  task automatic xfer(input logic w, input logic [31:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output int lat);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; lat = 0;
    #1;
    while (!ready) begin
      @(negedge clk); #1; lat++;
    end
    rd = rdata;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk(!ready && !mem_en, "R10 idle after reset", {30'd0, ready, mem_en}, 32'd0);
  endtask

  task automatic t_plain();
    logic [31:0] rd; int lat;
    xfer(1'b1, PLAIN | 32'h14, 32'hA5C3_0F96, rd, lat);
    chk(lat == 0, "R1 plain write latency", lat, 0);
    xfer(1'b0, PLAIN | 32'h14, 32'h0, rd, lat);
    chk(rd == 32'hA5C3_0F96, "R2 plain readback", rd, 32'hA5C3_0F96);
    chk(lat == 1, "R2 plain read latency", lat, 1);
  endtask

  // lane i holds a = i[3:2], b = i[1:0]
  task automatic t_func_all(input int f, input string tag);
    logic [31:0] aw, bw, rd, exp; int lat;
    for (int i = 0; i < 16; i++) begin
      aw[2*i +: 2] = 2'(i >> 2);
      bw[2*i +: 2] = 2'(i);
    end
    xfer(1'b1, PLAIN | 32'h20, bw, rd, lat);
    xfer(1'b1, fbase(f) | 32'h20, aw, rd, lat);
    chk(lat == 1, "R8 function write latency", lat, 1);
    exp = ref_word(f, aw, bw);
    xfer(1'b0, PLAIN | 32'h20, 32'h0, rd, lat);
    chk(rd == exp, tag, rd, exp);
  endtask

  task automatic t_patterns();
    logic [31:0] lf, aw, bw, rd, exp; int lat;
    lf = 32'h1234_5678;
    for (int k = 0; k < 8; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]}; bw = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]}; aw = lf ^ 32'h9E37_79B9;
      xfer(1'b1, PLAIN | 32'(k << 2), bw, rd, lat);
      xfer(1'b1, fbase((k % 4) + 1) | 32'(k << 2), aw, rd, lat);
      exp = ref_word((k % 4) + 1, aw, bw);
      xfer(1'b0, PLAIN | 32'(k << 2), 32'h0, rd, lat);
      chk(rd == exp, "R7 mixed lane pattern", rd, exp);
    end
  endtask

  task automatic t_last_word();
    logic [31:0] rd, exp; int lat;
    xfer(1'b1, PLAIN | 32'hFC, 32'h3333_0000, rd, lat);
    xfer(1'b1, F4 | 32'hFC, 32'h5555_5555, rd, lat);
    exp = ref_word(4, 32'h5555_5555, 32'h3333_0000);
    xfer(1'b0, PLAIN | 32'hFC, 32'h0, rd, lat);
    chk(rd == exp, "R8 last word alias R6", rd, exp);
  endtask

  task automatic t_ignored();
    logic [31:0] rd; int lat;
    xfer(1'b1, PLAIN | 32'h40, 32'hCAFE_F00D, rd, lat);
    xfer(1'b1, 32'h0800_0040, 32'h0000_0000, rd, lat);
    chk(lat == 0, "R9 outside window latency", lat, 0);
    xfer(1'b0, F2 | 32'h40, 32'h0, rd, lat);
    chk(rd == 32'h0 && lat == 0, "R9 function window read", rd, 32'h0);
    xfer(1'b0, PLAIN | 32'h40, 32'h0, rd, lat);
    chk(rd == 32'hCAFE_F00D, "R9 memory untouched", rd, 32'hCAFE_F00D);
    #1;
    chk(rdata == 32'h0, "R2 rdata idle zero", rdata, 32'h0);
  endtask

  initial begin
    n_run = 0; n_fail = 0; finished = 0;
    req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    t_reset();
    t_plain();
    t_func_all(1, "R3 product function");
    t_func_all(2, "R4 ceiling function");
    t_func_all(3, "R5 inverse product function");
    t_func_all(4, "R6 screen function");
    t_patterns();
    t_last_word();
    t_ignored();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule